// File: doc/BRIEF.md
# Exact Half-to-Single Float Widener

This block converts a 16-bit half-precision floating-point value into the single-precision bit pattern with the same value. It does not do arithmetic. It takes the sign, exponent and fraction fields apart and puts them back together in the wider layout. No value is rounded, and no exception flags are produced. Infinities are carried across unchanged. NaN payloads are carried across bit for bit, so a signalling NaN stays signalling.

Half subnormals are renormalised into normal single values. This uses the leading-zero count of the 10-bit fraction. A separate flush input can instead turn half subnormals into a zero that keeps its sign. An elaboration parameter selects between two variants. One is purely combinational. The other has an output register that loads only when the input is marked valid.

Top module: `half_to_single_widener`

## Requirements
- R1: Output bit 31 always equals input bit 15, in every class and under either flush setting.
- R2: Input exponent field bits 14:10 all ones gives output exponent bits 30:23 = 0xFF. The 10-bit input fraction appears unchanged at output bits 22:13. Example: 0x7C01 (signalling NaN) gives 0x7F802000.
- R3: Input exponent E in the range 1..30 gives output exponent E+112. The input fraction is placed at bits 22:13. Example: 0x3C00 gives 0x3F800000.
- R4: Input exponent 0 with fraction 0 gives a signed zero (bits 30:0 all zero), whatever the flush input is.
- R5: Input exponent 0 with a non-zero fraction, while flushSub is 1, gives a signed zero.
- R6: Input exponent 0 with a non-zero fraction, while flushSub is 0, gives output exponent 112 − L. Here L is the count of leading zeros in the 10-bit fraction. The fraction is shifted left by L+1, and its low 10 bits go to bits 22:13. Example: 0x0001 gives 0x33800000.
- R7: Output bits 12:0 are always zero.
- R8: flushSub has no effect on normal, zero, infinite or NaN inputs.
- R9: In the registered variant, outValid equals the inValid of the previous clock. The result for an input sampled with inValid high appears after that same edge.
- R10: In the registered variant, singleOut holds its value across any clock edge at which inValid is low.
- R11: While rstN is low, the registered variant drives outValid = 0 and singleOut = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register and the checks |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks halfIn as valid; load enable of the output register |
| halfIn | input | 16 | Half-precision operand |
| flushSub | input | 1 | Forces half subnormals to signed zero when 1 |
| outValid | output | 1 | Result valid |
| singleOut | output | 32 | Single-precision result |

## Verification
The state inside the block is the class decision and the leading-zero count. An error in either is visible on the very next registered result. A wrong class usually shows as an exponent field of 0xFF or 0x00 where an ordinary value was expected. A leading-zero count that is off by one shows as an exponent one step away from the expected value, together with a fraction that still holds the implicit one. Both forms of error are caught by sweeping all 65536 inputs under both flush settings against a real-number model. Holding and valid timing are checked on the cycle after each idle or valid edge.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int HALF_W    = 16;
  localparam int H_EXP_W   = 5;
  localparam int H_FRAC_W  = 10;
  localparam int H_BIAS    = 15;
  localparam int SGL_W     = 32;
  localparam int S_EXP_W   = 8;
  localparam int S_FRAC_W  = 23;
  localparam int S_BIAS    = 127;
  localparam int BIAS_GAP  = S_BIAS - H_BIAS;
  localparam int FRAC_PAD  = S_FRAC_W - H_FRAC_W;
  localparam int LZC_W     = $clog2(H_FRAC_W + 1);
  localparam int SHIFT_W   = LZC_W + 1;

  // Exactly one strobe is raised for every input pattern.
  typedef struct packed {
    logic pickSpecial;
    logic pickNormal;
    logic pickZero;
    logic pickRenorm;
  } classStrb_t;
endpackage

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkEn,
  input  logic [HALF_W-1:0] halfIn,
  input  logic              flushSub,
  output classStrb_t        strb
);
  logic [H_EXP_W-1:0] expField;
  logic               expAllOnes;
  logic               expZero;
  logic               fracNonZero;

  assign expField    = halfIn[HALF_W-2 -: H_EXP_W];
  assign expAllOnes  = &expField;
  assign expZero     = ~|expField;
  assign fracNonZero = |halfIn[H_FRAC_W-1:0];

  always_comb begin
    strb             = '0;
    strb.pickSpecial = expAllOnes;
    strb.pickNormal  = !expAllOnes && !expZero;
    strb.pickZero    = expZero && (!fracNonZero || flushSub);
    strb.pickRenorm  = expZero && fracNonZero && !flushSub;
  end

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    chkEn |-> $countones(strb) == 1); // R3

  AST_FLUSH_BLOCKS_RENORM: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && flushSub) |-> !strb.pickRenorm); // R5
endmodule

// File: rtl/hws_datapath.sv
module hws_datapath
  import hws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkEn,
  input  logic [HALF_W-1:0] halfIn,
  input  classStrb_t        strb,
  output logic [SGL_W-1:0]  resWord
);
  logic                 signBit;
  logic [H_EXP_W-1:0]   hExp;
  logic [H_FRAC_W-1:0]  hFrac;
  logic [LZC_W-1:0]     leadZeros;
  logic [SHIFT_W-1:0]   shiftAmt;
  logic [H_FRAC_W-1:0]  renFrac;
  logic [S_EXP_W-1:0]   renExp;
  logic [S_EXP_W-1:0]   normExp;
  logic [S_EXP_W-1:0]   outExp;
  logic [H_FRAC_W-1:0]  outFrac;

  assign signBit = halfIn[HALF_W-1];
  assign hExp    = halfIn[HALF_W-2 -: H_EXP_W];
  assign hFrac   = halfIn[H_FRAC_W-1:0];

  function automatic logic [LZC_W-1:0] countLead(input logic [H_FRAC_W-1:0] v);
    logic [LZC_W-1:0] n;
    logic             seen;
    n    = '0;
    seen = 1'b0;
    for (int i = H_FRAC_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  assign leadZeros = countLead(hFrac);
  assign shiftAmt  = SHIFT_W'(leadZeros) + SHIFT_W'(1);
  assign renFrac   = hFrac << shiftAmt;
  assign renExp    = S_EXP_W'(BIAS_GAP + 1) - S_EXP_W'(shiftAmt);
  assign normExp   = S_EXP_W'(hExp) + S_EXP_W'(BIAS_GAP);

  always_comb begin
    outExp  = '0;
    outFrac = '0;
    if (strb.pickSpecial) begin
      outExp  = '1;
      outFrac = hFrac;
    end else if (strb.pickNormal) begin
      outExp  = normExp;
      outFrac = hFrac;
    end else if (strb.pickRenorm) begin
      outExp  = renExp;
      outFrac = renFrac;
    end
  end

  assign resWord = {signBit, outExp, outFrac, {FRAC_PAD{1'b0}}};

  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    chkEn |-> resWord[SGL_W-1] == halfIn[HALF_W-1]); // R1

  AST_SPECIAL_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && (&halfIn[HALF_W-2 -: H_EXP_W])) |->
      (resWord[SGL_W-2 -: S_EXP_W] == '1) &&
      (resWord[SGL_W-2-S_EXP_W -: H_FRAC_W] == halfIn[H_FRAC_W-1:0])); // R2

  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    chkEn |-> resWord[FRAC_PAD-1:0] == '0); // R7

  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && strb.pickZero) |-> resWord[SGL_W-2:0] == '0); // R4

  AST_RENORM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && strb.pickRenorm) |->
      (resWord[SGL_W-2 -: S_EXP_W] <= S_EXP_W'(BIAS_GAP)) &&
      (resWord[SGL_W-2 -: S_EXP_W] >= S_EXP_W'(BIAS_GAP - H_FRAC_W + 1))); // R6
endmodule

// File: rtl/half_to_single_widener.sv
module half_to_single_widener
  import hws_pkg::*;
#(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [HALF_W-1:0] halfIn,
  input  logic              flushSub,
  output logic              outValid,
  output logic [SGL_W-1:0]  singleOut
);
  classStrb_t       strb;
  logic [SGL_W-1:0] combWord;

  hws_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chkEn    (inValid),
    .halfIn   (halfIn),
    .flushSub (flushSub),
    .strb     (strb)
  );

  hws_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chkEn   (inValid),
    .halfIn  (halfIn),
    .strb    (strb),
    .resWord (combWord)
  );

  generate
    if (REGISTER_OUT) begin : g_reg
      logic             validQ;
      logic [SGL_W-1:0] wordQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ <= 1'b0;
          wordQ  <= '0;
        end else begin
          validQ <= inValid;
          if (inValid) wordQ <= combWord;
        end
      end

      assign outValid  = validQ;
      assign singleOut = wordQ;

      AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> outValid == $past(inValid)); // R9

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !$past(inValid)) |-> $stable(singleOut)); // R10
    end else begin : g_comb
      assign outValid  = inValid;
      assign singleOut = combWord;
    end
  endgenerate
endmodule

// File: tb/half_to_single_widener_tb.sv
`timescale 1ns/1ps
module half_to_single_widener_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] halfIn = '0;
  logic        flushSub = 1'b0;
  logic        outValid;
  logic [31:0] singleOut;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  half_to_single_widener #(.REGISTER_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .halfIn(halfIn),
    .flushSub(flushSub), .outValid(outValid), .singleOut(singleOut)
  );

  // {flush, half, expected single}
  localparam logic [48:0] VEC [15] = '{
    {1'b0, 16'h3C00, 32'h3F800000},  // R3 one
    {1'b0, 16'hC000, 32'hC0000000},  // R3 R1 minus two
    {1'b0, 16'h7BFF, 32'h477FE000},  // R3 largest finite
    {1'b1, 16'h0400, 32'h38800000},  // R8 smallest normal, flush set
    {1'b0, 16'h7C00, 32'h7F800000},  // R2 +inf
    {1'b1, 16'hFC00, 32'hFF800000},  // R2 R8 -inf, flush set
    {1'b0, 16'h7C01, 32'h7F802000},  // R2 signalling NaN kept
    {1'b1, 16'h7E00, 32'h7FC00000},  // R2 quiet NaN
    {1'b0, 16'h8000, 32'h80000000},  // R4 -0
    {1'b1, 16'h0000, 32'h00000000},  // R4 +0 flush set
    {1'b0, 16'h0001, 32'h33800000},  // R6 smallest subnormal
    {1'b0, 16'h03FF, 32'h387FC000},  // R6 largest subnormal
    {1'b0, 16'h0200, 32'h38000000},  // R6 top fraction bit only
    {1'b1, 16'h8001, 32'h80000000},  // R5 flushed negative
    {1'b1, 16'h03FF, 32'h00000000}   // R5 flushed positive
  };

  function automatic logic [31:0] modelWiden(input logic [15:0] h, input logic fl);
    logic        s;
    int          e;
    int          f;
    int          ex;
    real         m;
    logic [31:0] r;
    s = h[15];
    e = int'(h[14:10]);
    f = int'(h[9:0]);
    if (e == 31) return {s, 8'hFF, h[9:0], 13'b0};
    if (e == 0 && (f == 0 || fl)) return {s, 31'b0};
    if (e == 0) m = real'(f) * (2.0 ** (-24.0));
    else m = (1.0 + real'(f) / 1024.0) * (2.0 ** (real'(e) - 15.0));
    ex = 0;
    while (m >= 2.0) begin m = m / 2.0; ex++; end
    while (m < 1.0) begin m = m * 2.0; ex--; end
    r[31]    = s;
    r[30:23] = 8'(ex + 127);
    r[22:0]  = 23'(longint'((m - 1.0) * 8388608.0));
    return r;
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic applyOne(input logic [15:0] h, input logic fl);
    halfIn   = h;
    flushSub = fl;
    inValid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] held;
    halfIn  = 16'h3C00;
    inValid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R11 reset outValid", {31'b0, outValid}, 32'h0);
    checkEq("R11 reset singleOut", singleOut, 32'h0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 15; i++) begin
      applyOne(VEC[i][47:32], VEC[i][48]);
      checkEq($sformatf("table %0d (R1-tag per row) half %04h", i, VEC[i][47:32]),
              singleOut, VEC[i][31:0]);
    end

    // R9 valid lag
    applyOne(16'h4000, 1'b0);
    checkEq("R9 outValid after valid edge", {31'b0, outValid}, 32'h1);
    checkEq("R9 result after valid edge", singleOut, 32'h40000000);

    // R10 hold while idle
    held    = singleOut;
    inValid = 1'b0;
    halfIn  = 16'h7C01;
    @(posedge clk);
    @(negedge clk);
    checkEq("R9 outValid drops", {31'b0, outValid}, 32'h0);
    halfIn = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R10 hold while idle", singleOut, held);

    // Full sweep under both flush settings: R1 R2 R3 R4 R5 R6 R7 R8
    for (int fl = 0; fl < 2; fl++) begin
      for (int v = 0; v < 65536; v++) begin
        applyOne(16'(v), fl[0]);
        checkEq($sformatf("sweep R1 R2 R3 R4 R5 R6 R7 R8 flush=%0d half=%04h", fl, v),
                singleOut, modelWiden(16'(v), fl[0]));
        if (singleOut[12:0] != 13'b0) checkEq("R7 low bits", {19'b0, singleOut[12:0]}, 32'h0);
      end
    end

    inValid = 1'b0;
    finishRun();
  end
endmodule